// File: doc/BRIEF.md
# Reloadable down-counter interrupt timer

A 32-bit down-counting timer behind a small word-addressed register port. Software picks one of three tick sources (or none), divides that source by a 12-bit prescale factor, and lets the counter run either in reload mode, where zero brings back the value held in the load register, or in free-running mode, where zero wraps to all ones. A compare register is checked each time the counter takes a new value. On a match a sticky status flag is set, and this flag can drive a level interrupt.

The register port is a plain single-cycle bus, not a stream. A write is captured on the clock edge on which `bus_sel` and `bus_wr` are both high. Read data is combinational from the current state while `bus_sel` is high and `bus_wr` is low. There is no back-pressure and no wait state. The tick sources arrive as one-cycle enable pulses in the timer's own clock domain. Control also carries a software reset command and an immediate-overwrite option for load writes. It stores four low-power gating bits without acting on them.

Top module: `pit_timer`

## Requirements
- R1: After a hardware reset, control reads 0, status reads 0, load reads 0xFFFFFFFF, compare reads 0, count reads 0 and `irq` is low.
- R2: The byte offsets are control 0x00, status 0x04, load 0x08, compare 0x0C and count 0x10. Only bits 25:0 of a control write are kept, and control bit 16 always reads 0. Writes to count are ignored. Reads of any other offset return 0.
- R3: Control bits 25:24 select the tick source: 00 none, 01 `src_tick[0]`, 10 `src_tick[1]`, 11 `src_tick[2]`. Control bits 15:4 hold a prescale value P. While enabled (control bit 0), the counter steps once for every P+1 pulses of the selected source, and the prescale count restarts when the timer is enabled or P is changed.
- R4: A step taken at count 0 loads the load register when control bit 3 is 1, and loads 0xFFFFFFFF when it is 0. Any other step decrements the count by one.
- R5: Status bit 0 is set in the cycle the count takes a new value equal to compare. Writing status with bit 0 = 1 clears the flag, and writing status with bit 0 = 0 leaves it unchanged.
- R6: `irq` is high exactly while status bit 0, control bit 2 and control bit 0 are all 1.
- R7: A control write with bit 16 set clears control bits 0, 1 and 21:18 and keeps the other written bits. It also clears status, sets load to 0xFFFFFFFF, clears compare and sets the count to 0xFFFFFFFF.
- R8: A load write while control bit 17 is 1 also puts the written value into the count at once. While bit 17 is 0, the count is untouched until the next reload.
- R9: A control write that takes bit 0 from 0 to 1 with bit 1 set starts the count from load (bit 3 = 1) or from 0xFFFFFFFF (bit 3 = 0). With bit 1 clear, the count resumes from its held value.
- R10: While control bit 0 is 0, the count holds its value whatever the tick inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| src_tick | input | 3 | Tick-enable pulses of the three selectable sources |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read |
| irq | output | 1 | Level interrupt request |

## Verification
The bench drives wrap-around at zero in both reload modes. A design that mixed up the two modes would show a load value where all ones were expected, or the reverse. A single tick is held against a prescale of two to catch an off-by-one in the divider. Sources are pulsed that the select code does not pick, to show that the source select does not leak. Enabling with and without the start-mode bit separates a restarted count from a resumed one. The bench also checks that a status write of 0 keeps the flag, which a design that cleared on any write would lose. It checks that the interrupt falls while the flag stays set once either gate bit is dropped. A software reset must leave exactly the kept control bits, and a wrong mask shows up as a different control readback.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int CTRL_W  = 26;
  localparam int B_EN    = 0;
  localparam int B_MOD   = 1;
  localparam int B_CIE   = 2;
  localparam int B_RLD   = 3;
  localparam int B_PS_LO = 4;
  localparam int PS_W    = 12;
  localparam int B_SWR   = 16;
  localparam int B_OVW   = 17;
  localparam int B_LP_LO = 18;
  localparam int LP_W    = 4;
  localparam int B_CS_LO = 24;
  localparam int CS_W    = 2;
  localparam int NSRC    = (1 << CS_W) - 1;

  // bits forced to zero by a software reset write
  localparam logic [CTRL_W-1:0] SWR_CLR =
    CTRL_W'((1 << B_EN) | (1 << B_MOD) | (1 << B_SWR) | (((1 << LP_W) - 1) << B_LP_LO));
  // bit never stored
  localparam logic [CTRL_W-1:0] NOSTORE = CTRL_W'(1 << B_SWR);

  localparam int OFS_CTRL = 'h00;
  localparam int OFS_STAT = 'h04;
  localparam int OFS_LOAD = 'h08;
  localparam int OFS_CMP  = 'h0C;
  localparam int OFS_CNT  = 'h10;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CTRL, SEL_STAT, SEL_LOAD, SEL_CMP, SEL_CNT
  } reg_sel_e;
endpackage

// File: rtl/pit_prescale.sv
module pit_prescale #(
  parameter int PS_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            src_in,
  input  logic            run,
  input  logic            restart,
  input  logic [PS_W-1:0] div,
  output logic            tick
);
  logic [PS_W-1:0] pcnt_q;
  logic            at_top;

  assign at_top = (pcnt_q == div);
  assign tick   = run && !restart && src_in && at_top;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
    end else if (restart || !run) begin
      pcnt_q <= '0;
    end else if (src_in) begin
      pcnt_q <= at_top ? '0 : pcnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pit_count.sv
module pit_count #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          swr,
  input  logic          start,
  input  logic [CW-1:0] start_val,
  input  logic          ovw,
  input  logic [CW-1:0] ovw_val,
  input  logic          step,
  input  logic [CW-1:0] reload_val,
  input  logic [CW-1:0] cmp_val,
  output logic [CW-1:0] cnt,
  output logic          match
);
  logic [CW-1:0] cnt_q, nxt;
  logic          take;

  always_comb begin
    take = 1'b1;
    nxt  = cnt_q;
    if (swr)        nxt = '1;
    else if (start) nxt = start_val;
    else if (ovw)   nxt = ovw_val;
    else if (step)  nxt = (cnt_q == '0) ? reload_val : cnt_q - 1'b1;
    else            take = 1'b0;
  end

  assign match = take && !swr && (nxt == cmp_val);
  assign cnt   = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (take) cnt_q <= nxt;
  end
endmodule

// File: rtl/pit_timer.sv
module pit_timer
  import pit_pkg::*;
#(
  parameter int CW = 32,
  parameter int AW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_tick,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [CW-1:0]   bus_wdata,
  output logic [CW-1:0]   bus_rdata,
  output logic            irq
);
  logic [CTRL_W-1:0] ctrl_q, ctrl_wv;
  logic              stat_q;
  logic [CW-1:0]     load_q, cmp_q, cnt_q;
  reg_sel_e          rsel;
  logic              wr_ctrl, wr_stat, wr_load, wr_cmp;
  logic              swr, en_rise, start, ovw, ps_restart, ptick, cnt_step, cnt_match;
  logic [NSRC:0]     src_vec;
  logic              src_pick;

  always_comb begin
    case (int'(bus_addr))
      OFS_CTRL: rsel = SEL_CTRL;
      OFS_STAT: rsel = SEL_STAT;
      OFS_LOAD: rsel = SEL_LOAD;
      OFS_CMP:  rsel = SEL_CMP;
      OFS_CNT:  rsel = SEL_CNT;
      default:  rsel = SEL_NONE;
    endcase
  end

  assign wr_ctrl = bus_sel && bus_wr && (rsel == SEL_CTRL);
  assign wr_stat = bus_sel && bus_wr && (rsel == SEL_STAT);
  assign wr_load = bus_sel && bus_wr && (rsel == SEL_LOAD);
  assign wr_cmp  = bus_sel && bus_wr && (rsel == SEL_CMP);

  assign ctrl_wv    = bus_wdata[CTRL_W-1:0];
  assign swr        = wr_ctrl && ctrl_wv[B_SWR];
  assign en_rise    = wr_ctrl && !swr && ctrl_wv[B_EN] && !ctrl_q[B_EN];
  assign start      = en_rise && ctrl_wv[B_MOD];
  assign ovw        = wr_load && ctrl_q[B_OVW];
  assign ps_restart = en_rise ||
                      (wr_ctrl && (ctrl_wv[B_PS_LO +: PS_W] != ctrl_q[B_PS_LO +: PS_W]));
  assign cnt_step   = ctrl_q[B_EN] && ptick && !wr_ctrl && !ovw;

  // source 0 of the select code is "no clock"
  assign src_vec  = {src_tick, 1'b0};
  assign src_pick = src_vec[ctrl_q[B_CS_LO +: CS_W]];

  pit_prescale #(.PS_W(PS_W)) u_ps (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_in  (src_pick),
    .run     (ctrl_q[B_EN]),
    .restart (ps_restart),
    .div     (ctrl_q[B_PS_LO +: PS_W]),
    .tick    (ptick)
  );

  pit_count #(.CW(CW)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .swr        (swr),
    .start      (start),
    .start_val  (ctrl_wv[B_RLD] ? load_q : {CW{1'b1}}),
    .ovw        (ovw),
    .ovw_val    (bus_wdata),
    .step       (cnt_step),
    .reload_val (ctrl_q[B_RLD] ? load_q : {CW{1'b1}}),
    .cmp_val    (cmp_q),
    .cnt        (cnt_q),
    .match      (cnt_match)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      stat_q <= 1'b0;
      load_q <= '1;
      cmp_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= swr ? (ctrl_wv & ~SWR_CLR) : (ctrl_wv & ~NOSTORE);
      if (swr) begin
        stat_q <= 1'b0;
        load_q <= '1;
        cmp_q  <= '0;
      end else begin
        if (cnt_match)                   stat_q <= 1'b1;
        else if (wr_stat && bus_wdata[0]) stat_q <= 1'b0;
        if (wr_load) load_q <= bus_wdata;
        if (wr_cmp)  cmp_q  <= bus_wdata;
      end
    end
  end

  assign irq = stat_q && ctrl_q[B_CIE] && ctrl_q[B_EN];

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (rsel)
        SEL_CTRL: bus_rdata = CW'(ctrl_q);
        SEL_STAT: bus_rdata = CW'(stat_q);
        SEL_LOAD: bus_rdata = load_q;
        SEL_CMP:  bus_rdata = cmp_q;
        SEL_CNT:  bus_rdata = cnt_q;
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/pit_timer_chk.sv
module pit_timer_chk
  import pit_pkg::*;
#(
  parameter int CW = 32,
  parameter int AW = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [AW-1:0]     bus_addr,
  input logic [CW-1:0]     bus_wdata,
  input logic              irq,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic              stat_q,
  input logic [CW-1:0]     load_q,
  input logic [CW-1:0]     cnt_q,
  input logic              cnt_step,
  input logic              cnt_match
);
  logic any_wr, wr_stat, wr_load, wr_ctrl;
  assign any_wr  = bus_sel && bus_wr;
  assign wr_ctrl = any_wr && (int'(bus_addr) == OFS_CTRL);
  assign wr_stat = any_wr && (int'(bus_addr) == OFS_STAT);
  assign wr_load = any_wr && (int'(bus_addr) == OFS_LOAD);

  a_r6_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[B_EN] || !ctrl_q[B_CIE] || !stat_q) |-> !irq);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[B_EN] && !any_wr) |=> $stable(cnt_q));

  a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_step && cnt_q == '0 && ctrl_q[B_RLD]) |=> cnt_q == $past(load_q));

  a_r8_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_load && ctrl_q[B_OVW]) |=> cnt_q == $past(bus_wdata));

  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && bus_wdata[0] && !cnt_match) |=> !stat_q);

  a_r7_swr: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && bus_wdata[B_SWR]) |=> (cnt_q == '1 && !stat_q && !ctrl_q[B_EN] && load_q == '1));
endmodule

bind pit_timer pit_timer_chk #(.CW(CW), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .irq       (irq),
  .ctrl_q    (ctrl_q),
  .stat_q    (stat_q),
  .load_q    (load_q),
  .cnt_q     (cnt_q),
  .cnt_step  (cnt_step),
  .cnt_match (cnt_match)
);

// File: tb/pit_timer_test.sv
module pit_timer_test;
  localparam int CLK_NS = 10;
  localparam logic [4:0] A_CTRL = 5'h00, A_STAT = 5'h04, A_LOAD = 5'h08,
                         A_CMP = 5'h0C, A_CNT = 5'h10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  src_tick = '0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  pit_timer uut (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  always #(CLK_NS/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [31:0] q_exp[$];
  string       q_tag[$];

  // monitor: scores each read against the queued expectation
  always @(negedge clk) begin
    if (rst_n && bus_sel && !bus_wr && q_exp.size() != 0) begin
      logic [31:0] e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        fails++;
        $display("FAIL %s actual=%h expected=%h", t, bus_rdata, e);
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] e, input string t);
    @(posedge clk); #1;
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    q_exp.push_back(e); q_tag.push_back(t);
    @(posedge clk); #1;
    bus_sel = 1'b0;
  endtask

  task automatic hold(input logic [2:0] s, input int n);
    @(posedge clk); #1;
    src_tick = s;
    repeat (n) @(posedge clk);
    #1 src_tick = '0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    checks++;
    if (irq !== e) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", t, irq, e);
    end
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    rd(A_CTRL, 32'h0, "R1 ctrl");
    rd(A_STAT, 32'h0, "R1 stat");
    rd(A_LOAD, 32'hFFFF_FFFF, "R1 load");
    rd(A_CMP,  32'h0, "R1 cmp");
    rd(A_CNT,  32'h0, "R1 cnt");
    chk_irq(1'b0, "R1 irq");
    // R2 map
    wr(A_CNT, 32'h5);
    rd(A_CNT, 32'h0, "R2 count read-only");
    rd(5'h14, 32'h0, "R2 unmapped");
    wr(A_CTRL, 32'hFFFE_0000);
    rd(A_CTRL, 32'h03FE_0000, "R2 ctrl mask");
    // R7 software reset
    wr(A_LOAD, 32'h5);
    wr(A_CMP, 32'h3);
    wr(A_CTRL, 32'h03FF_0FFF);
    rd(A_CTRL, 32'h03C2_0FFC, "R7 ctrl kept bits");
    rd(A_LOAD, 32'hFFFF_FFFF, "R7 load");
    rd(A_CMP,  32'h0, "R7 cmp");
    rd(A_CNT,  32'hFFFF_FFFF, "R7 cnt");
    rd(A_STAT, 32'h0, "R7 stat");
    // R9/R4/R5 reload mode, prescale 0, source 01
    wr(A_CTRL, 32'h0);
    wr(A_LOAD, 32'h3);
    wr(A_CMP, 32'h1);
    wr(A_CTRL, 32'h0100_000F);
    rd(A_CNT, 32'h3, "R9 start from load");
    hold(3'b001, 1);
    rd(A_CNT, 32'h2, "R3 one step");
    rd(A_STAT, 32'h0, "R5 no match yet");
    hold(3'b001, 1);
    rd(A_STAT, 32'h1, "R5 match sets flag");
    chk_irq(1'b1, "R6 irq on");
    hold(3'b001, 2);
    rd(A_CNT, 32'h3, "R4 reload from load");
    wr(A_STAT, 32'h0);
    rd(A_STAT, 32'h1, "R5 write 0 no effect");
    wr(A_STAT, 32'h1);
    rd(A_STAT, 32'h0, "R5 write 1 clears");
    chk_irq(1'b0, "R6 irq off after clear");
    // R6 gating
    hold(3'b001, 2);
    chk_irq(1'b1, "R6 irq after second match");
    wr(A_CTRL, 32'h0100_000B);
    chk_irq(1'b0, "R6 irq masked by enable bit 2");
    rd(A_STAT, 32'h1, "R6 flag kept while masked");
    wr(A_CTRL, 32'h0100_000F);
    chk_irq(1'b1, "R6 irq unmasked");
    // R10 disabled hold
    wr(A_CTRL, 32'h0100_000E);
    chk_irq(1'b0, "R6 irq off when disabled");
    hold(3'b111, 2);
    rd(A_CNT, 32'h1, "R10 hold while disabled");
    // R9 resume without start mode
    wr(A_CTRL, 32'h0100_000D);
    rd(A_CNT, 32'h1, "R9 resume keeps count");
    wr(A_STAT, 32'h1);
    hold(3'b001, 2);
    rd(A_CNT, 32'h3, "R4 reload after resume");
    // R4 free-running wrap
    wr(A_CTRL, 32'h0100_0005);
    hold(3'b001, 4);
    rd(A_CNT, 32'hFFFF_FFFF, "R4 wrap to all ones");
    rd(A_STAT, 32'h1, "R5 flag in free run");
    // R8 immediate overwrite
    wr(A_CTRL, 32'h0102_0005);
    wr(A_LOAD, 32'h7);
    rd(A_CNT, 32'h7, "R8 overwrite now");
    wr(A_CTRL, 32'h0100_0005);
    wr(A_LOAD, 32'h9);
    rd(A_CNT, 32'h7, "R8 no overwrite");
    rd(A_LOAD, 32'h9, "R8 load stored");
    // R9 start with reload select 0, R3 prescale 2
    wr(A_CTRL, 32'h0);
    wr(A_CTRL, 32'h0100_0023);
    rd(A_CNT, 32'hFFFF_FFFF, "R9 start all ones");
    hold(3'b001, 2);
    rd(A_CNT, 32'hFFFF_FFFF, "R3 prescale two pulses");
    hold(3'b001, 1);
    rd(A_CNT, 32'hFFFF_FFFE, "R3 prescale third pulse");
    // R3 source select
    wr(A_CTRL, 32'h0);
    wr(A_CTRL, 32'h0000_0001);
    hold(3'b111, 1);
    rd(A_CNT, 32'hFFFF_FFFE, "R3 source 00 no clock");
    wr(A_CTRL, 32'h0300_0001);
    hold(3'b011, 1);
    rd(A_CNT, 32'hFFFF_FFFE, "R3 source 11 ignores others");
    hold(3'b100, 1);
    rd(A_CNT, 32'hFFFF_FFFD, "R3 source 11 steps");
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule